// File: doc/BRIEF.md
# Versatile Interface Adapter: Timers and Interrupt Core

This block is a byte-wide register peripheral with sixteen host-visible slots. It holds two 16-bit down-counters, a data byte for a shift unit, an auxiliary control byte, a peripheral control byte, two port data bytes and their direction bytes, and a pair of interrupt flag and enable bytes. A single active-high interrupt line is raised whenever a pending flag is also enabled. Both counters decrement only on cycles where the `tick` input is high, so the counting rate is set by whatever divider drives that input.

The host selects a slot with `reg_sel` and pulses `rd_en` or `wr_en`. Read data is a combinational function of the selected slot and is valid in the same cycle as the strobe. Reading or writing certain counter bytes, and reading the shift byte, clear the matching flag at the end of that cycle. The external shift logic reports a finished byte with a one-cycle `shift_done` pulse.

The first counter runs a four-state machine. Its states are IDLE (after reset, counting freely with no flag), RUN (loaded, heading for the crossing), WRAP (continuous mode, one tick past the crossing, waiting to reload) and DONE (one-shot spent, counting freely). A counter-high write moves it from any state to RUN. From RUN, a crossing moves it to WRAP in continuous mode and to DONE otherwise. From WRAP, the next tick moves it to RUN with a reload, or to DONE if continuous mode has been switched off. The second counter has a three-state machine. Its states are IDLE, RUN and DONE, with the same load and crossing transitions and no WRAP state.

Top module: `via_timer_core`

## Requirements
- R1: After reset, slot 2 (port B direction) reads 0xFF and the first counter's latch reads 0xFFFF. Every other stored byte reads 0, and `irq` is low.
- R2: A write to a port data slot (0 = port B, 1 = port A, 15 = port A alias) changes only the bits whose direction bit is 1. Slots 2 and 3 hold the port B and port A direction bytes.
- R3: `irq` is high exactly when (flags & enables & 0x64) is nonzero. The flag bits are bit 6 for the first counter, bit 5 for the second counter and bit 2 for the shift byte.
- R4: Reading slot 13 returns the flags in bits 6:0, with bit 7 set when any flag is both pending and enabled. Reading slot 14 returns the enables in bits 6:0, with bit 7 always 1.
- R5: A write to slot 14 with bit 7 set ORs bits 6:0 into the enables. A write with bit 7 clear clears every enable bit written as 1. A write to slot 13 clears every flag bit written as 1.
- R6: Slot 4 or 6 writes set the first latch's low byte. A slot 5 write sets the latch high byte, loads the counter with the whole latch, enters RUN and clears flag bit 6. A slot 7 write sets the latch high byte and clears flag bit 6, but does not touch the counter.
- R7: Reading slot 4 clears flag bit 6. Reading slot 8 clears flag bit 5. Reading slot 10 clears flag bit 2.
- R8: When slot 11 bits 7:6 are 01 (continuous), the first counter sets flag bit 6 on every tick that takes it from 0 to 0xFFFF. On the next tick it reloads from the latch, so flags are latch+2 ticks apart.
- R9: When slot 11 bits 7:6 are not 01 (one-shot), the first counter sets flag bit 6 only on the first crossing after a load. After that it keeps counting with no further flags.
- R10: Slot 8 writes set the second latch byte. A slot 9 write loads the second counter as {written byte, latch byte} and clears flag bit 5. The second counter then sets flag bit 5 once, on its first 0 to 0xFFFF tick.
- R11: The counters change only on cycles with `tick` high. A load write in the same cycle as a tick takes priority over the tick.
- R12: If a flag-setting event and a clearing access hit the same flag in one cycle, the flag ends up set.
- R13: A `shift_done` pulse sets flag bit 2.
- R14: Slots 5 and 4 read the first counter's high and low bytes, and slots 7 and 6 read its latch. Slots 9 and 8 read the second counter. Slots 10, 11 and 12 hold the shift, auxiliary and peripheral control bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for both counters |
| reg_sel | input | 4 | Register slot index |
| rd_en | input | 1 | Read strobe (drives read side effects) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected slot, combinational |
| shift_done | input | 1 | Shift byte complete pulse |
| irq | output | 1 | Interrupt request, active high |

## Verification
`rd_data` depends only on state, so a read is checked in the cycle its strobe is driven. Any write, tick, `shift_done` pulse or read side effect shows up after the next rising edge. `irq` rises or falls one cycle after the tick or access that changes a flag. The bench drives inputs just after a falling edge and samples 1 ns later. A behavioural model, advanced on each rising edge, supplies the expected `irq` every cycle and the expected read data on every read. Hand-computed values cover the crossing ticks and the flag-clearing accesses.

// File: rtl/via_pkg.sv
package via_pkg;

    typedef enum logic [3:0] {
        RG_PB      = 4'd0,
        RG_PA      = 4'd1,
        RG_DIRB    = 4'd2,
        RG_DIRA    = 4'd3,
        RG_T1C_LO  = 4'd4,
        RG_T1C_HI  = 4'd5,
        RG_T1L_LO  = 4'd6,
        RG_T1L_HI  = 4'd7,
        RG_T2_LO   = 4'd8,
        RG_T2_HI   = 4'd9,
        RG_SHIFT   = 4'd10,
        RG_AUX     = 4'd11,
        RG_PCTL    = 4'd12,
        RG_IFLAG   = 4'd13,
        RG_IEN     = 4'd14,
        RG_PA_ALT  = 4'd15
    } reg_idx_e;

    localparam int FB_T1 = 6;
    localparam int FB_T2 = 5;
    localparam int FB_SR = 2;
    localparam logic [6:0] IRQ_MASK = 7'h64;

    typedef enum logic [1:0] {T1_IDLE, T1_RUN, T1_WRAP, T1_DONE} t1_state_e;
    typedef enum logic [1:0] {T2_IDLE, T2_RUN, T2_DONE} t2_state_e;

endpackage

// File: rtl/via_t1.sv
module via_t1 #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  cont_mode,
    input  logic                  wr_lat_lo,
    input  logic                  wr_lat_hi,
    input  logic                  wr_cnt_hi,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [2*BYTE_W-1:0]   count,
    output logic [2*BYTE_W-1:0]   latch,
    output logic                  fire
);
    localparam int CW = 2 * BYTE_W;
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    via_pkg::t1_state_e state, state_nxt;
    logic [CW-1:0] cnt_nxt, lat_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= via_pkg::T1_IDLE;
            count <= '0;
            latch <= '1;
        end else begin
            state <= state_nxt;
            count <= cnt_nxt;
            latch <= lat_nxt;
        end
    end

    always_comb begin
        lat_nxt = latch;
        if (wr_lat_lo) lat_nxt[BYTE_W-1:0] = wdata;
        if (wr_lat_hi || wr_cnt_hi) lat_nxt[CW-1:BYTE_W] = wdata;
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = count;
        fire      = 1'b0;
        if (wr_cnt_hi) begin
            cnt_nxt   = {wdata, latch[BYTE_W-1:0]};
            state_nxt = via_pkg::T1_RUN;
        end else if (tick) begin
            unique case (state)
                via_pkg::T1_IDLE, via_pkg::T1_DONE: begin
                    cnt_nxt = count - ONE;
                end
                via_pkg::T1_RUN: begin
                    if (count == '0) begin
                        fire      = 1'b1;
                        cnt_nxt   = '1;
                        state_nxt = cont_mode ? via_pkg::T1_WRAP : via_pkg::T1_DONE;
                    end else begin
                        cnt_nxt = count - ONE;
                    end
                end
                via_pkg::T1_WRAP: begin
                    if (cont_mode) begin
                        cnt_nxt   = latch;
                        state_nxt = via_pkg::T1_RUN;
                    end else begin
                        cnt_nxt   = count - ONE;
                        state_nxt = via_pkg::T1_DONE;
                    end
                end
                default: begin
                    state_nxt = via_pkg::T1_IDLE;
                end
            endcase
        end
    end

    p_t1_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_hi |=> (count == {$past(wdata), $past(latch[BYTE_W-1:0])}));

    p_t1_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_cnt_hi) |=> $stable(count));

    p_t1_oneshot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !cont_mode) |=> (state == via_pkg::T1_DONE));

    p_t1_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == via_pkg::T1_WRAP && tick && cont_mode && !wr_cnt_hi)
        |=> (count == $past(latch)));

endmodule

// File: rtl/via_t2.sv
module via_t2 #(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  wr_lat_lo,
    input  logic                  wr_cnt_hi,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [2*BYTE_W-1:0]   count,
    output logic                  fire
);
    localparam int CW = 2 * BYTE_W;
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    via_pkg::t2_state_e state, state_nxt;
    logic [CW-1:0]     cnt_nxt;
    logic [BYTE_W-1:0] latch_lo;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= via_pkg::T2_IDLE;
            count    <= '0;
            latch_lo <= '1;
        end else begin
            state <= state_nxt;
            count <= cnt_nxt;
            if (wr_lat_lo) latch_lo <= wdata;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = count;
        fire      = 1'b0;
        if (wr_cnt_hi) begin
            cnt_nxt   = {wdata, latch_lo};
            state_nxt = via_pkg::T2_RUN;
        end else if (tick) begin
            unique case (state)
                via_pkg::T2_RUN: begin
                    if (count == '0) begin
                        fire      = 1'b1;
                        state_nxt = via_pkg::T2_DONE;
                    end
                    cnt_nxt = count - ONE;
                end
                via_pkg::T2_IDLE, via_pkg::T2_DONE: begin
                    cnt_nxt = count - ONE;
                end
                default: begin
                    state_nxt = via_pkg::T2_IDLE;
                end
            endcase
        end
    end

    p_t2_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_hi |=> (count == {$past(wdata), $past(latch_lo)}) && (state == via_pkg::T2_RUN));

    p_t2_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_cnt_hi) |=> $stable(count));

endmodule

// File: rtl/via_irq.sv
module via_irq #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BYTE_W-2:0]   set_vec,
    input  logic [BYTE_W-2:0]   clr_vec,
    input  logic                ien_wr,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [BYTE_W-2:0]   flags,
    output logic [BYTE_W-2:0]   enables,
    output logic                irq,
    output logic                pending
);
    localparam int NF = BYTE_W - 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags   <= '0;
            enables <= '0;
        end else begin
            flags <= (flags & ~clr_vec) | set_vec;
            if (ien_wr) begin
                enables <= wdata[BYTE_W-1] ? (enables | wdata[NF-1:0])
                                           : (enables & ~wdata[NF-1:0]);
            end
        end
    end

    always_comb begin
        irq     = |(flags & enables & via_pkg::IRQ_MASK[NF-1:0]);
        pending = |(flags & enables);
    end

    for (genvar g = 0; g < NF; g++) begin : g_flag_chk
        p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[g] |=> flags[g]);
        p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[g] && !set_vec[g]) |=> !flags[g]);
    end

    p_ien_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_wr && wdata[BYTE_W-1]) |=> ((enables & $past(wdata[NF-1:0])) == $past(wdata[NF-1:0])));

endmodule

// File: rtl/via_timer_core.sv
module via_timer_core #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [3:0]        reg_sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              shift_done,
    output logic              irq
);
    localparam int CW = 2 * BYTE_W;
    localparam int NF = BYTE_W - 1;

    logic [BYTE_W-1:0] pb, pa, dirb, dira, shreg, aux, pctl;
    logic [CW-1:0]     t1_cnt, t1_lat, t2_cnt;
    logic              t1_fire, t2_fire, pending, cont_mode;
    logic [NF-1:0]     flags, enables, set_vec, clr_vec;
    via_pkg::reg_idx_e idx;

    assign idx       = via_pkg::reg_idx_e'(reg_sel);
    assign cont_mode = (aux[BYTE_W-1 -: 2] == 2'b01);

    function automatic logic wr_hit(input via_pkg::reg_idx_e cur, input via_pkg::reg_idx_e want, input logic we);
        return we && (cur == want);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pb    <= '0;
            pa    <= '0;
            dirb  <= '1;
            dira  <= '0;
            shreg <= '0;
            aux   <= '0;
            pctl  <= '0;
        end else if (wr_en) begin
            unique case (idx)
                via_pkg::RG_PB:                   pb    <= (pb & ~dirb) | (wr_data & dirb);
                via_pkg::RG_PA, via_pkg::RG_PA_ALT: pa  <= (pa & ~dira) | (wr_data & dira);
                via_pkg::RG_DIRB:                 dirb  <= wr_data;
                via_pkg::RG_DIRA:                 dira  <= wr_data;
                via_pkg::RG_SHIFT:                shreg <= wr_data;
                via_pkg::RG_AUX:                  aux   <= wr_data;
                via_pkg::RG_PCTL:                 pctl  <= wr_data;
                default: ;
            endcase
        end
    end

    via_t1 #(.BYTE_W(BYTE_W)) u_t1 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cont_mode (cont_mode),
        .wr_lat_lo (wr_hit(idx, via_pkg::RG_T1C_LO, wr_en) || wr_hit(idx, via_pkg::RG_T1L_LO, wr_en)),
        .wr_lat_hi (wr_hit(idx, via_pkg::RG_T1L_HI, wr_en)),
        .wr_cnt_hi (wr_hit(idx, via_pkg::RG_T1C_HI, wr_en)),
        .wdata     (wr_data),
        .count     (t1_cnt),
        .latch     (t1_lat),
        .fire      (t1_fire)
    );

    via_t2 #(.BYTE_W(BYTE_W)) u_t2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_lat_lo (wr_hit(idx, via_pkg::RG_T2_LO, wr_en)),
        .wr_cnt_hi (wr_hit(idx, via_pkg::RG_T2_HI, wr_en)),
        .wdata     (wr_data),
        .count     (t2_cnt),
        .fire      (t2_fire)
    );

    always_comb begin
        set_vec = '0;
        set_vec[via_pkg::FB_T1] = t1_fire;
        set_vec[via_pkg::FB_T2] = t2_fire;
        set_vec[via_pkg::FB_SR] = shift_done;
    end

    always_comb begin
        clr_vec = '0;
        if (wr_hit(idx, via_pkg::RG_IFLAG, wr_en)) clr_vec = wr_data[NF-1:0];
        if (wr_hit(idx, via_pkg::RG_T1C_LO, rd_en) || wr_hit(idx, via_pkg::RG_T1C_HI, wr_en)
            || wr_hit(idx, via_pkg::RG_T1L_HI, wr_en))
            clr_vec[via_pkg::FB_T1] = 1'b1;
        if (wr_hit(idx, via_pkg::RG_T2_LO, rd_en) || wr_hit(idx, via_pkg::RG_T2_HI, wr_en))
            clr_vec[via_pkg::FB_T2] = 1'b1;
        if (wr_hit(idx, via_pkg::RG_SHIFT, rd_en))
            clr_vec[via_pkg::FB_SR] = 1'b1;
    end

    via_irq #(.BYTE_W(BYTE_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .ien_wr  (wr_hit(idx, via_pkg::RG_IEN, wr_en)),
        .wdata   (wr_data),
        .flags   (flags),
        .enables (enables),
        .irq     (irq),
        .pending (pending)
    );

    always_comb begin
        unique case (idx)
            via_pkg::RG_PB:                     rd_data = pb;
            via_pkg::RG_PA, via_pkg::RG_PA_ALT: rd_data = pa;
            via_pkg::RG_DIRB:                   rd_data = dirb;
            via_pkg::RG_DIRA:                   rd_data = dira;
            via_pkg::RG_T1C_LO:                 rd_data = t1_cnt[BYTE_W-1:0];
            via_pkg::RG_T1C_HI:                 rd_data = t1_cnt[CW-1:BYTE_W];
            via_pkg::RG_T1L_LO:                 rd_data = t1_lat[BYTE_W-1:0];
            via_pkg::RG_T1L_HI:                 rd_data = t1_lat[CW-1:BYTE_W];
            via_pkg::RG_T2_LO:                  rd_data = t2_cnt[BYTE_W-1:0];
            via_pkg::RG_T2_HI:                  rd_data = t2_cnt[CW-1:BYTE_W];
            via_pkg::RG_SHIFT:                  rd_data = shreg;
            via_pkg::RG_AUX:                    rd_data = aux;
            via_pkg::RG_PCTL:                   rd_data = pctl;
            via_pkg::RG_IFLAG:                  rd_data = {pending, flags};
            via_pkg::RG_IEN:                    rd_data = {1'b1, enables};
            default:                            rd_data = '0;
        endcase
    end

    p_port_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == 4'd0) |=> (((pb ^ $past(pb)) & ~$past(dirb)) == '0));

endmodule

// File: tb/sim_via_timer_core.sv
module sim_via_timer_core;
    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rd_en = 1'b0, wr_en = 1'b0, shift_done = 1'b0;
    logic [3:0] reg_sel = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq;

    always #2 clk = ~clk;

    via_timer_core u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .reg_sel(reg_sel), .rd_en(rd_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .shift_done(shift_done), .irq(irq)
    );

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit    finished = 0;

    // behavioural reference state
    int m_pb, m_pa, m_dirb, m_dira, m_sr, m_acr, m_pcr, m_ifr, m_ier;
    int m_t1c, m_t1l, m_t1s, m_t2c, m_t2l, m_t2s;
    int s_i, d_i, setm, clrm;
    bit cont;

    function automatic int m_read(input int s);
        case (s)
            0: return m_pb;
            1, 15: return m_pa;
            2: return m_dirb;
            3: return m_dira;
            4: return m_t1c % 256;
            5: return m_t1c / 256;
            6: return m_t1l % 256;
            7: return m_t1l / 256;
            8: return m_t2c % 256;
            9: return m_t2c / 256;
            10: return m_sr;
            11: return m_acr;
            12: return m_pcr;
            13: return m_ifr + (((m_ifr & m_ier) != 0) ? 128 : 0);
            default: return m_ier + 128;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pb = 0; m_pa = 0; m_dirb = 255; m_dira = 0; m_sr = 0; m_acr = 0; m_pcr = 0;
            m_ifr = 0; m_ier = 0; m_t1c = 0; m_t1l = 65535; m_t1s = 0;
            m_t2c = 0; m_t2l = 255; m_t2s = 0;
        end else begin
            s_i = int'(reg_sel); d_i = int'(wr_data); setm = 0; clrm = 0;
            cont = ((m_acr / 64) % 4) == 1;
            if (wr_en && s_i == 5) begin
                m_t1c = d_i * 256 + (m_t1l % 256); m_t1s = 1;
            end else if (tick) begin
                if (m_t1s == 1) begin
                    if (m_t1c == 0) begin setm = setm | 64; m_t1c = 65535; m_t1s = cont ? 2 : 3; end
                    else m_t1c = m_t1c - 1;
                end else if (m_t1s == 2) begin
                    if (cont) begin m_t1c = m_t1l; m_t1s = 1; end
                    else begin m_t1c = m_t1c - 1; m_t1s = 3; end
                end else m_t1c = (m_t1c + 65535) % 65536;
            end
            if (wr_en && (s_i == 4 || s_i == 6)) m_t1l = (m_t1l / 256) * 256 + d_i;
            if (wr_en && (s_i == 5 || s_i == 7)) m_t1l = d_i * 256 + (m_t1l % 256);
            if (wr_en && s_i == 9) begin
                m_t2c = d_i * 256 + m_t2l; m_t2s = 1;
            end else if (tick) begin
                if (m_t2s == 1 && m_t2c == 0) begin setm = setm | 32; m_t2s = 2; end
                m_t2c = (m_t2c + 65535) % 65536;
            end
            if (wr_en && s_i == 8) m_t2l = d_i;
            if (shift_done) setm = setm | 4;
            if (rd_en && s_i == 4) clrm = clrm | 64;
            if (wr_en && (s_i == 5 || s_i == 7)) clrm = clrm | 64;
            if ((rd_en && s_i == 8) || (wr_en && s_i == 9)) clrm = clrm | 32;
            if (rd_en && s_i == 10) clrm = clrm | 4;
            if (wr_en && s_i == 13) clrm = clrm | (d_i % 128);
            m_ifr = (m_ifr & ~clrm & 127) | setm;
            if (wr_en && s_i == 14) begin
                if (d_i >= 128) m_ier = m_ier | (d_i % 128);
                else m_ier = m_ier & ~d_i & 127;
            end
            if (wr_en) begin
                case (s_i)
                    0: m_pb = (m_pb & ~m_dirb & 255) | (d_i & m_dirb);
                    1, 15: m_pa = (m_pa & ~m_dira & 255) | (d_i & m_dira);
                    2: m_dirb = d_i;
                    3: m_dira = d_i;
                    10: m_sr = d_i;
                    11: m_acr = d_i;
                    12: m_pcr = d_i;
                    default: ;
                endcase
            end
        end
    end

    task automatic cyc(input bit tk, input bit rd, input bit wr, input int s, input int d, input bit sd);
        bit exp_irq;
        @(negedge clk);
        tick = tk; rd_en = rd; wr_en = wr; reg_sel = 4'(s); wr_data = 8'(d); shift_done = sd;
        #1;
        exp_irq = (m_ifr & m_ier & 'h64) != 0;
        n_chk++;
        if (irq !== exp_irq) begin
            n_fail++;
            $display("FAIL %s (R3 model) irq got %0b exp %0b", cur_req, irq, exp_irq);
        end
        if (rd) begin
            n_chk++;
            if (rd_data !== 8'(m_read(s))) begin
                n_fail++;
                $display("FAIL %s model read slot %0d got %02h exp %02h", cur_req, s, rd_data, 8'(m_read(s)));
            end
        end
    endtask

    task automatic rd_chk(input int s, input int exp);
        cyc(0, 1, 0, s, 0, 0);
        n_chk++;
        if (rd_data !== 8'(exp)) begin
            n_fail++;
            $display("FAIL %s slot %0d got %02h exp %02h", cur_req, s, rd_data, 8'(exp));
        end
    endtask

    task automatic wr(input int s, input int d);
        cyc(0, 0, 1, s, d, 0);
    endtask

    task automatic idle(input int n, input bit tk);
        for (int i = 0; i < n; i++) cyc(tk, 0, 0, 0, 0, 0);
    endtask

    task automatic irq_chk(input bit exp);
        cyc(0, 0, 0, 0, 0, 0);
        n_chk++;
        if (irq !== exp) begin
            n_fail++;
            $display("FAIL %s irq got %0b exp %0b", cur_req, irq, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog run incomplete got timeout exp completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        rd_chk(2, 'hFF); rd_chk(3, 0); rd_chk(0, 0); rd_chk(6, 'hFF); rd_chk(7, 'hFF);
        rd_chk(11, 0); rd_chk(13, 0); irq_chk(0);
        cur_req = "R4";
        rd_chk(14, 'h80);
        cur_req = "R2";
        wr(0, 'hA5); rd_chk(0, 'hA5);
        wr(3, 'h0F); wr(1, 'hFF); rd_chk(1, 'h0F);
        wr(15, 'hF3); rd_chk(15, 'h03);
        wr(2, 'hF0); wr(0, 'h0F); rd_chk(0, 'h05);
        cur_req = "R13";
        cyc(0, 0, 0, 0, 0, 1); rd_chk(13, 'h04); irq_chk(0);
        cur_req = "R5";
        wr(14, 'hE0); rd_chk(14, 'hE0); wr(14, 'h20); rd_chk(14, 'hC0);
        wr(14, 'h84); rd_chk(14, 'hC4);
        cur_req = "R3";
        irq_chk(1);
        cur_req = "R4";
        rd_chk(13, 'h84);
        cur_req = "R5";
        wr(13, 'h04); rd_chk(13, 0); irq_chk(0);
        cur_req = "R7";
        cyc(0, 0, 0, 0, 0, 1); rd_chk(10, 0); rd_chk(13, 0);
        cur_req = "R12";
        cyc(0, 1, 0, 10, 0, 1); rd_chk(13, 'h84); wr(13, 'h7F);
        cur_req = "R6";
        wr(11, 0); wr(4, 5); wr(5, 0); rd_chk(6, 5); rd_chk(7, 0);
        cur_req = "R11";
        idle(3, 0); rd_chk(4, 5); rd_chk(5, 0);
        cur_req = "R9";
        idle(5, 1); rd_chk(13, 0); irq_chk(0);
        idle(1, 1); rd_chk(13, 'hC0); irq_chk(1);
        idle(10, 1); rd_chk(5, 'hFF); rd_chk(4, 'hF5); rd_chk(13, 0);
        idle(65530, 1); rd_chk(13, 0); rd_chk(5, 'hFF); rd_chk(4, 'hFB);
        cur_req = "R6";
        wr(6, 3); wr(5, 0); idle(4, 1); rd_chk(13, 'hC0);
        wr(7, 'h12); rd_chk(13, 0); rd_chk(5, 'hFF); rd_chk(7, 'h12);
        cur_req = "R8";
        wr(11, 'h40); wr(6, 2); wr(5, 0);
        idle(3, 1); rd_chk(13, 'hC0); rd_chk(5, 'hFF); wr(13, 'h40);
        idle(1, 1); rd_chk(4, 2); rd_chk(13, 0);
        idle(2, 1); rd_chk(13, 0);
        idle(1, 1); rd_chk(13, 'hC0);
        cur_req = "R11";
        wr(11, 0); wr(14, 'h44); wr(14, 'hA0); wr(13, 'h7F);
        wr(8, 3); cyc(1, 0, 1, 9, 0, 0); rd_chk(8, 3); rd_chk(9, 0);
        cur_req = "R10";
        idle(3, 1); irq_chk(0); idle(1, 1); irq_chk(1); rd_chk(13, 'hA0);
        cur_req = "R7";
        rd_chk(8, 'hFF); irq_chk(0);
        cur_req = "R10";
        idle(5, 1); irq_chk(0); rd_chk(8, 'hFA);
        wr(9, 0); idle(4, 1); irq_chk(1); wr(9, 0); irq_chk(0); rd_chk(8, 3);
        cur_req = "R14";
        wr(12, 'h5A); rd_chk(12, 'h5A); wr(10, 'h3C); rd_chk(10, 'h3C); rd_chk(11, 0);
        report();
    end
endmodule